// File: doc/BRIEF.md
# Grouped DMA Event Interrupt Controller

This block gathers ten completion and error events from a DMA bridge into one 32-bit control and status word. There are two USB events: transfer done and address error. There are also eight audio events. Each of two audio channels signals a full buffer and a half buffer, separately for play and for record. Every event has an enable flag and a sticky status flag. A single-cycle pulse on an event input sets its status flag, and the flag stays set until software writes a zero to it.

The block drives three interrupt request lines, grouped by the kind of event. The first line carries the USB address error alone. The second carries USB transfer done and the four full-buffer audio events. The third carries the four half-buffer audio events. A line is high while any event in its group is both pending and enabled.

Software reads the word and then writes it back with zeros in the status bits it has handled. It can rewrite the enables in the same access. The read data is a continuous view of the register. A write takes effect at the clock edge on which `reg_valid` and `reg_write` are both high.

Top module: `dma_event_irq_ctrl`

## Requirements
- R1: After reset, the read word is 0x00000000 and all three request lines are low.
- R2: Event identifiers are 0 = USB transfer done and 1 = USB address error. Identifiers 2..9 are, in this order: channel 0 play full, play half, record full, record half, then the same four for channel 1. Status bit positions are: event i at bit i for i<2, and bit i+14 for i>=2. Each enable bit sits 8 positions above its status bit.
- R3: A pulse on `evt_pulse[i]` sets status i at the next clock edge, whatever the state of enable i.
- R4: A write with a 0 in a status bit clears that flag. A write with a 1 leaves the flag unchanged.
- R5: A write loads every enable bit with the written value.
- R6: When an event pulse and a write clearing the same status bit fall on the same edge, the status bit ends up set.
- R7: `irq_req[0]` is high exactly when event 1 is pending and enabled. `irq_req[1]` is high exactly when any of events 0, 2, 4, 6, 8 is pending and enabled. `irq_req[2]` is high exactly when any of events 3, 5, 7, 9 is pending and enabled.
- R8: Bits 15..10 and 7..2 always read as zero, and writes to them have no effect.
- R9: A cycle with `reg_valid` or `reg_write` low changes no enable bit and clears no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write when high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register word |
| evt_pulse | input | 10 | Single-cycle event pulses, bit i = event i |
| irq_req | output | 3 | Grouped interrupt request lines |

## Verification
Every stimulus is captured at one rising edge. The read word and the request lines settle in that same cycle, since both are plain logic on the enable and status flops. The bench changes inputs on the falling edge and samples one nanosecond after the next rising edge, so each check sees the result of exactly one access or pulse. For the R6 collision, the pulse and the clearing write are placed in the same falling-edge slot.

// File: rtl/dma_event_irq_ctrl.sv
module dma_event_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  input  logic        reg_write,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [9:0]  evt_pulse,
  output logic [2:0]  irq_req
);
  localparam int NEVT = 10;

  logic [NEVT-1:0] en_q, st_q, wr_en, wr_st, pend;
  logic wr;

  assign wr = reg_valid && reg_write;

  // unpack write data into per-event enable and status views
  assign wr_en = {reg_wdata[31:24], reg_wdata[9:8]};
  assign wr_st = {reg_wdata[23:16], reg_wdata[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else if (wr) begin
      en_q <= wr_en;
      st_q <= evt_pulse | (st_q & wr_st);
    end else begin
      st_q <= st_q | evt_pulse;
    end
  end

  assign reg_rdata = {en_q[9:2], st_q[9:2], 6'b0, en_q[1:0], 6'b0, st_q[1:0]};

  assign pend = en_q & st_q;
  assign irq_req[0] = pend[1];
  assign irq_req[1] = pend[0] | pend[2] | pend[4] | pend[6] | pend[8];
  assign irq_req[2] = pend[3] | pend[5] | pend[7] | pend[9];

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((st_q & $past(st_q)) == $past(st_q)));

  p_pulse_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((st_q & $past(evt_pulse)) == $past(evt_pulse)));

  p_enable_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ({reg_rdata[31:24], reg_rdata[9:8]} == {$past(reg_wdata[31:24]), $past(reg_wdata[9:8])}));

  p_enable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_q));

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:10] == 6'b0) && (reg_rdata[7:2] == 6'b0));

  p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (irq_req == 3'b000));
endmodule

// File: tb/tb_dma_event_irq_ctrl.sv
module tb_dma_event_irq_ctrl;
  logic clk = 0, rst_n = 0, reg_valid = 0, reg_write = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [9:0] evt_pulse = '0;
  logic [2:0] irq_req;
  int n_chk = 0, n_bad = 0;
  logic [9:0] m_en = '0, m_st = '0;

  dma_event_irq_ctrl dut (.*);

  always #5 clk = ~clk;

  function automatic int st_pos(int i);
    return (i < 2) ? i : i + 14;
  endfunction

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int i = 0; i < 10; i++) begin
      w[st_pos(i)] = m_st[i];
      w[st_pos(i) + 8] = m_en[i];
    end
    return w;
  endfunction

  function automatic logic [2:0] model_irq();
    logic [9:0] p = m_en & m_st;
    return {p[3] | p[5] | p[7] | p[9], p[0] | p[2] | p[4] | p[6] | p[8], p[1]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " word"}, reg_rdata, model_word());
    check({req, " irq"}, {29'b0, irq_req}, {29'b0, model_irq()});
  endtask

  // one clock of stimulus; model follows the requirements
  task automatic step(logic v, logic w, logic [31:0] d, logic [9:0] e);
    @(negedge clk);
    reg_valid = v; reg_write = w; reg_wdata = d; evt_pulse = e;
    @(posedge clk);
    #1;
    reg_valid = 0; reg_write = 0; reg_wdata = '0; evt_pulse = '0;
    if (v && w) begin
      for (int i = 0; i < 10; i++) begin
        m_en[i] = d[st_pos(i) + 8];
        m_st[i] = e[i] | (m_st[i] & d[st_pos(i)]);
      end
    end else m_st = m_st | e;
  endtask

  task automatic t_reset();
    check("R1 word", reg_rdata, 32'h0);
    check("R1 irq", {29'b0, irq_req}, 32'h0);
  endtask

  task automatic t_latch_masked();
    step(0, 0, '0, 10'h3FF);
    check("R3 R2 masked latch", reg_rdata, 32'h00FF0003);
    check("R3 irq stays low", {29'b0, irq_req}, 32'h0);
  endtask

  task automatic t_write_ones();
    step(1, 1, 32'hFFFFFFFF, '0);
    check("R4 R5 R8 ones", reg_rdata, 32'hFFFF0303);
    check("R7 all lines", {29'b0, irq_req}, 32'h7);
    step(1, 1, 32'hFF000300, '0);
    check("R4 clear all", reg_rdata, 32'hFF000300);
    check("R7 none pending", {29'b0, irq_req}, 32'h0);
  endtask

  task automatic t_each_event();
    for (int i = 0; i < 10; i++) begin
      step(0, 0, '0, 10'(1 << i));
      check($sformatf("R2 event %0d word", i), reg_rdata, 32'hFF000300 | (32'h1 << st_pos(i)));
      check_all($sformatf("R7 event %0d", i));
      step(1, 1, 32'hFF000300, '0);
    end
  endtask

  task automatic t_collision();
    step(1, 1, 32'hFF000300, 10'(1 << 5));
    check("R6 pulse wins", reg_rdata, 32'hFF080300);
    check_all("R6");
  endtask

  task automatic t_no_strobe();
    step(0, 1, 32'h0, '0);
    check_all("R9 valid low");
    step(1, 0, 32'h0, '0);
    check_all("R9 write low");
    check("R9 word kept", reg_rdata, 32'hFF080300);
  endtask

  task automatic t_mask();
    step(1, 1, 32'h00FF0003, '0);
    check("R5 disable keeps status", reg_rdata, 32'h00080000);
    check("R7 masked", {29'b0, irq_req}, 32'h0);
    step(1, 1, 32'h00000200, 10'h002);
    check_all("R7 line0 only");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        t_reset();
        t_latch_masked();
        t_write_ones();
        t_each_event();
        t_collision();
        t_no_strobe();
        t_mask();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule